// File: doc/BRIEF.md
# Posted Write Combining Buffer

This block sits on the downstream side of a bus bridge and absorbs memory writes. Each incoming write carries a word address, four active-low byte enables and a 32-bit data word. A write is acknowledged in the same cycle it is offered, provided the queue has room for it. The block then forwards the write later, on its own schedule, as part of a burst. There is no wait for the far side to finish or even begin the transfer.

While writes wait in the queue, the newest stored word can absorb later traffic in three ways:
- a write to the next ascending word extends the current burst;
- a write that skips exactly one word extends the burst with a filler phase in which no byte is enabled;
- a write to the same word merges into it, provided its enabled bytes do not clash with the bytes already stored.

A write whose bytes collide with stored bytes is queued as a separate phase. This keeps both values in arrival order, so a later write never quietly replaces an earlier one.

The output presents one data phase at a time with a valid/ready handshake. Each phase carries its own word address, data and byte enables. A start flag marks the phase that opens a burst and so carries the burst's start address.

Top module: `wcb_post_buffer`

## Requirements
- R1: The queue holds 8 phases. A write is refused (`in_ready` low) when it needs more free phases than remain: a new burst or an extension needs 1, a one-word gap fill needs 2, a merge or an empty write needs 0.
- R2: A write that needs no more phases than are free is acknowledged (`in_ready` high) in the cycle it is offered. Its phase is presented at the output no later than the cycle after the accepting edge.
- R3: A write to the word directly above the newest stored phase is appended as a phase with `out_start` = 0.
- R4: A write two words above the newest stored phase first inserts a filler phase at the skipped address, with byte enables 4'b1111, data 0 and `out_start` = 0. The write itself follows as a phase with `out_start` = 0. A filler never opens a burst.
- R5: A write that is below the newest stored word, lands more than two words above it, or arrives with no combinable tail opens a new burst (`out_start` = 1).
- R6: A write to the newest stored word whose enabled bytes are disjoint from that phase's enabled bytes is merged into it. The byte enables become their union, and the new bytes take their lanes (lane i is `data[8i+7:8i]`, enabled when `be_n[i]` = 0).
- R7: A write to the newest stored word that shares any enabled byte with it is stored as a new phase with `out_start` = 1, after the earlier one.
- R8: A write with all four byte enables off is acknowledged, even when the queue is full, and produces no output phase.
- R9: While `out_valid` is high and `out_ready` is low, every output field stays unchanged.
- R10: Combining only considers the newest stored phase. A write to the word of an older queued phase opens a new burst.
- R11: The phase currently offered at the output is never combined with. With a single phase stored, every write opens a new burst.
- R12: Data lanes whose byte enable is off read as zero at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| in_valid | input | 1 | Incoming write offered |
| in_ready | output | 1 | Write accepted this cycle (low = retry) |
| in_addr | input | 32 | Word address of the write |
| in_be_n | input | 4 | Active-low byte enables, bit i for lane i |
| in_data | input | 32 | Write data |
| out_valid | output | 1 | A data phase is offered |
| out_ready | input | 1 | Far side takes the phase this cycle |
| out_start | output | 1 | Phase opens a burst |
| out_addr | output | 32 | Word address of the phase |
| out_be_n | output | 4 | Active-low byte enables of the phase |
| out_data | output | 32 | Data of the phase |

## Verification
`in_ready` is a combinational answer, so the bench drives a write just after a falling edge and reads `in_ready` one nanosecond later, within that same cycle. A stored phase reaches the output registers at the next rising edge. The bench therefore loads the queue with `out_ready` low and only then opens the output. Phases leave on rising edges where valid and ready are both high, so the monitor samples the output handshake midway through the low clock phase. At that point it pops the expected phase from the scoreboard queue, in order. Stability under stall is probed across several idle cycles after loading.

// File: rtl/wcb_pkg.sv
`timescale 1ns/1ps
package wcb_pkg;

    localparam int WCB_AW    = 32;
    localparam int WCB_DW    = 32;
    localparam int WCB_LANES = WCB_DW / 8;

    typedef enum logic [2:0] {
        ACT_DROP,
        ACT_MERGE,
        ACT_APPEND,
        ACT_GAP,
        ACT_OPEN
    } wcb_act_e;

    typedef struct packed {
        logic [WCB_AW-1:0]    addr;
        logic [WCB_DW-1:0]    data;
        logic [WCB_LANES-1:0] be_n;
        logic                 start;
    } wcb_entry_t;

    function automatic logic [WCB_DW-1:0] lane_mask(input logic [WCB_LANES-1:0] be_n);
        logic [WCB_DW-1:0] m;
        for (int i = 0; i < WCB_LANES; i++) begin
            m[8*i +: 8] = {8{~be_n[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/wcb_classify.sv
`timescale 1ns/1ps
module wcb_classify
    import wcb_pkg::*;
(
    input  logic                 tail_live,
    input  logic [WCB_AW-1:0]    tail_addr,
    input  logic [WCB_LANES-1:0] tail_be_n,
    input  logic [WCB_AW-1:0]    wr_addr,
    input  logic [WCB_LANES-1:0] wr_be_n,
    output wcb_act_e             act,
    output logic [1:0]           slots
);

    logic [WCB_AW:0] t_ext;
    logic [WCB_AW:0] w_ext;
    logic            clash;

    always_comb begin
        t_ext = {1'b0, tail_addr};
        w_ext = {1'b0, wr_addr};
        clash = |(~tail_be_n & ~wr_be_n);
        act   = ACT_OPEN;
        slots = 2'd1;
        if (&wr_be_n) begin
            act   = ACT_DROP;
            slots = 2'd0;
        end else if (tail_live && (w_ext == t_ext) && !clash) begin
            act   = ACT_MERGE;
            slots = 2'd0;
        end else if (tail_live && (w_ext == t_ext + (WCB_AW+1)'(1))) begin
            act   = ACT_APPEND;
            slots = 2'd1;
        end else if (tail_live && (w_ext == t_ext + (WCB_AW+1)'(2))) begin
            act   = ACT_GAP;
            slots = 2'd2;
        end
    end

endmodule

// File: rtl/wcb_store.sv
`timescale 1ns/1ps
module wcb_store
    import wcb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  wcb_act_e             act,
    input  logic [WCB_AW-1:0]    wr_addr,
    input  logic [WCB_LANES-1:0] wr_be_n,
    input  logic [WCB_DW-1:0]    wr_data,
    input  logic                 pop,
    output wcb_entry_t           head,
    output logic [WCB_AW-1:0]    tail_addr,
    output logic [WCB_LANES-1:0] tail_be_n,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        wcb_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]          wr;
        logic [PW-1:0]          rd;
        logic [CW-1:0]          cnt;
    } store_t;

    store_t            st_d, st_q;
    logic [PW-1:0]     last;
    logic [CW-1:0]     add;
    logic [WCB_DW-1:0] mask;
    wcb_entry_t        fresh;
    wcb_entry_t        filler;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] back(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
    endfunction

    always_comb begin
        st_d  = st_q;
        add   = '0;
        last  = back(st_q.wr);
        mask  = lane_mask(wr_be_n);
        fresh = '{addr: wr_addr, data: wr_data & mask, be_n: wr_be_n, start: 1'b0};
        filler = '{addr: st_q.mem[last].addr + WCB_AW'(1), data: '0, be_n: '1, start: 1'b0};
        if (accept) begin
            unique case (act)
                ACT_MERGE: begin
                    st_d.mem[last].be_n = st_q.mem[last].be_n & wr_be_n;
                    st_d.mem[last].data = (st_q.mem[last].data & ~mask) | (wr_data & mask);
                end
                ACT_APPEND: begin
                    st_d.mem[st_q.wr] = fresh;
                    st_d.wr           = step(st_q.wr);
                    add               = CW'(1);
                end
                ACT_GAP: begin
                    st_d.mem[st_q.wr]       = filler;
                    st_d.mem[step(st_q.wr)] = fresh;
                    st_d.wr                 = step(step(st_q.wr));
                    add                     = CW'(2);
                end
                ACT_OPEN: begin
                    st_d.mem[st_q.wr]       = fresh;
                    st_d.mem[st_q.wr].start = 1'b1;
                    st_d.wr                 = step(st_q.wr);
                    add                     = CW'(1);
                end
                default: ;
            endcase
        end
        if (pop) begin
            st_d.rd = step(st_q.rd);
        end
        st_d.cnt = st_q.cnt + add - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head      = st_q.mem[st_q.rd];
    assign tail_addr = st_q.mem[last].addr;
    assign tail_be_n = st_q.mem[last].be_n;
    assign count     = st_q.cnt;

    // R1: occupancy never passes the queue depth
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= DEPTH_C)
        else $error("queue overflow");

    // R6: a merge never moves the write pointer
    p_merge_in_place_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && act == ACT_MERGE) |=> (st_q.wr == $past(st_q.wr)))
        else $error("merge allocated a phase");

endmodule

// File: rtl/wcb_post_buffer.sv
`timescale 1ns/1ps
module wcb_post_buffer
    import wcb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WCB_AW-1:0]    in_addr,
    input  logic [WCB_LANES-1:0] in_be_n,
    input  logic [WCB_DW-1:0]    in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_start,
    output logic [WCB_AW-1:0]    out_addr,
    output logic [WCB_LANES-1:0] out_be_n,
    output logic [WCB_DW-1:0]    out_data
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    wcb_act_e             act;
    logic [1:0]           slots;
    logic [CW-1:0]        count;
    logic [CW-1:0]        free_slots;
    logic                 tail_live;
    logic                 accept;
    logic                 pop;
    wcb_entry_t           head;
    logic [WCB_AW-1:0]    tail_addr;
    logic [WCB_LANES-1:0] tail_be_n;

    // the phase at the output is never a combining target
    assign tail_live  = (count >= CW'(2));
    assign free_slots = DEPTH_C - count;
    assign in_ready   = (free_slots >= CW'(slots));
    assign accept     = in_valid && in_ready;
    assign out_valid  = (count != '0);
    assign pop        = out_valid && out_ready;

    assign out_start = head.start;
    assign out_addr  = head.addr;
    assign out_be_n  = head.be_n;
    assign out_data  = head.data;

    wcb_classify u_classify (
        .tail_live (tail_live),
        .tail_addr (tail_addr),
        .tail_be_n (tail_be_n),
        .wr_addr   (in_addr),
        .wr_be_n   (in_be_n),
        .act       (act),
        .slots     (slots)
    );

    wcb_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .act       (act),
        .wr_addr   (in_addr),
        .wr_be_n   (in_be_n),
        .wr_data   (in_data),
        .pop       (pop),
        .head      (head),
        .tail_addr (tail_addr),
        .tail_be_n (tail_be_n),
        .count     (count)
    );

    // R2: an accepted write with data is visible at the output next cycle
    p_posted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !(&in_be_n)) |=> out_valid)
        else $error("accepted write not presented");

    // R9: a stalled phase holds still
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)
                                       && $stable(out_be_n) && $stable(out_start)))
        else $error("output changed while stalled");

    // R5: after an idle output the first phase opens a burst
    p_opens_after_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_start)
        else $error("burst continued from an idle output");

    // R4: a phase with no byte enabled never opens a burst
    p_filler_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&out_be_n)) |-> !out_start)
        else $error("empty phase opened a burst");

endmodule

// File: tb/test_wcb_post_buffer.sv
`timescale 1ns/1ps
module test_wcb_post_buffer;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  b;
        logic        s;
    } ph_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [3:0]  in_be_n = 4'hF;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_start;
    logic [31:0] out_addr;
    logic [3:0]  out_be_n;
    logic [31:0] out_data;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    ph_t   expq[$];
    string tagq[$];

    always #10 clk = ~clk;

    wcb_post_buffer i_wcb_post_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_addr   (in_addr),
        .in_be_n   (in_be_n),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_start (out_start),
        .out_addr  (out_addr),
        .out_be_n  (out_be_n),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [68:0] act, input logic [68:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ex(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b,
                      input logic s, input string tag);
        expq.push_back('{a: a, d: d, b: b, s: s});
        tagq.push_back(tag);
    endtask

    task automatic wr(input logic [31:0] a, input logic [3:0] bn, input logic [31:0] d,
                      input bit exp_rdy, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        in_be_n  = bn;
        in_data  = d;
        #1;
        chk(in_ready == exp_rdy, tag, 69'(in_ready), 69'(exp_rdy));
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_be_n  = 4'hF;
    endtask

    task automatic drain(input string tag);
        @(negedge clk);
        out_ready = 1'b1;
        for (int i = 0; i < 100 && expq.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(expq.size() == 0 && !out_valid, tag, 69'(expq.size()), 69'(0));
        out_ready = 1'b0;
    endtask

    // scoreboard monitor: samples mid low phase
    always @(negedge clk) begin
        #5;
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R8 unexpected phase", {out_addr, out_data, out_be_n, out_start}, '0);
            end else begin
                ph_t   e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk({out_addr, out_data, out_be_n, out_start} == e, t,
                    {out_addr, out_data, out_be_n, out_start}, e);
            end
        end
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!out_valid, "R2 reset out_valid", 69'(out_valid), 69'(0));
        chk(in_ready, "R2 reset in_ready", 69'(in_ready), 69'(1));

        // ascending, gap fill, wide gap and descending writes
        wr(32'h08, 4'h0, 32'hA0A0A0A0, 1'b1, "R2 accept first");
        @(negedge clk);
        chk(out_valid, "R2 posted at output", 69'(out_valid), 69'(1));
        ex(32'h08, 32'hA0A0A0A0, 4'h0, 1'b1, "R11 single phase opens");
        wr(32'h10, 4'h0, 32'h11111111, 1'b1, "R5 accept");
        ex(32'h10, 32'h11111111, 4'h0, 1'b1, "R5 gap over two words opens");
        wr(32'h11, 4'h0, 32'h22222222, 1'b1, "R3 accept");
        ex(32'h11, 32'h22222222, 4'h0, 1'b0, "R3 ascending appended");
        wr(32'h13, 4'h0, 32'h33333333, 1'b1, "R4 accept");
        ex(32'h12, 32'h00000000, 4'hF, 1'b0, "R4 filler phase");
        ex(32'h13, 32'h33333333, 4'h0, 1'b0, "R4 write after filler");
        wr(32'h20, 4'hE, 32'h444444C4, 1'b1, "R5 accept wide gap");
        ex(32'h20, 32'h000000C4, 4'hE, 1'b1, "R12 wide gap opens, lanes zeroed");
        wr(32'h1F, 4'h0, 32'h55555555, 1'b1, "R5 accept descending");
        ex(32'h1F, 32'h55555555, 4'h0, 1'b1, "R5 descending opens");
        repeat (3) @(negedge clk);
        #1;
        chk(out_addr == 32'h08 && out_start && out_data == 32'hA0A0A0A0,
            "R9 stalled head held", 69'(out_addr), 69'(32'h08));
        drain("R3 drain sequence one");

        // merge, clash, older word, empty write
        wr(32'h30, 4'h0, 32'h0D0D0D0D, 1'b1, "R2 accept");
        ex(32'h30, 32'h0D0D0D0D, 4'h0, 1'b1, "R5 dummy head");
        wr(32'h40, 4'hC, 32'h1111BBAA, 1'b1, "R6 accept low lanes");
        wr(32'h40, 4'h3, 32'hDDCC2222, 1'b1, "R6 accept high lanes");
        ex(32'h40, 32'hDDCCBBAA, 4'h0, 1'b1, "R6 disjoint lanes merged");
        wr(32'h40, 4'hE, 32'h333333EE, 1'b1, "R7 accept clash");
        ex(32'h40, 32'h000000EE, 4'hE, 1'b1, "R7 clash kept separate");
        wr(32'h41, 4'hD, 32'h4444FF44, 1'b1, "R3 accept");
        ex(32'h41, 32'h0000FF00, 4'hD, 1'b0, "R12 appended lanes zeroed");
        wr(32'h40, 4'hD, 32'h55557755, 1'b1, "R10 accept older word");
        ex(32'h40, 32'h00007700, 4'hD, 1'b1, "R10 older word opens");
        wr(32'h40, 4'hF, 32'hFFFFFFFF, 1'b1, "R8 empty write acknowledged");
        drain("R8 no phase from empty write");

        // single stored phase is never a combining target
        wr(32'h300, 4'h0, 32'h01020304, 1'b1, "R11 accept");
        wr(32'h301, 4'h0, 32'h05060708, 1'b1, "R11 accept next word");
        ex(32'h300, 32'h01020304, 4'h0, 1'b1, "R11 head");
        ex(32'h301, 32'h05060708, 4'h0, 1'b1, "R11 next word opens");
        drain("R11 drain");

        // capacity limits
        for (int i = 0; i < 7; i++) begin
            wr(32'h100 + 32'(4 * i), 4'h0, 32'hC0DE0000 + 32'(i), 1'b1, "R1 fill");
            ex(32'h100 + 32'(4 * i), 32'hC0DE0000 + 32'(i), 4'h0, 1'b1, "R1 filled phase");
        end
        wr(32'h11A, 4'h0, 32'h99999999, 1'b0, "R1 gap fill refused with one free");
        wr(32'h119, 4'hE, 32'hAAAAAA01, 1'b1, "R1 append takes last phase");
        wr(32'h200, 4'h0, 32'h77777777, 1'b0, "R1 new burst refused when full");
        wr(32'h119, 4'hD, 32'hBBBB02BB, 1'b1, "R6 merge accepted when full");
        wr(32'h500, 4'hF, 32'h12345678, 1'b1, "R8 empty write accepted when full");
        ex(32'h119, 32'h00000201, 4'hC, 1'b0, "R6 merged into full tail");
        drain("R1 drain full queue");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule